// File: doc/BRIEF.md
# LIN Slave Break Detector and Synch-Field Timer

This block sits on the receive side of a LIN slave node. It watches the serial receive line for a break, meaning a long run of dominant (low) level that marks the start of a frame. When it finds one, it raises a status flag and, if enabled, an interrupt request. Break detection does not depend on whether the data receiver is enabled.

Once a break is seen, the block waits for the line to return high. It then times the synch byte (0x55) that follows. A measurement window opens on the first falling edge of that byte and closes on its fifth falling edge, which spans exactly eight bit times. The block counts system clocks while the window is open and publishes the total with a one-cycle done pulse. Software divides this count by eight to get clocks per bit, and from that derives the new baud divisor.

If the count would exceed its register width, the measurement is abandoned and an overflow flag is raised instead.

Top module: `lin_sync_meter`

## Requirements
- R1: A break is recognised when the synchronised receive line has been low for BREAK_BITS*NOM_BIT_CLKS consecutive clocks (176 with the defaults). A low run that is shorter does not set brk_flag.
- R2: When brk_ie is 1, brk_flag and irq go high in the same clock cycle when a break is recognised.
- R3: When brk_ie is 0, a recognised break still sets brk_flag, but irq stays 0.
- R4: A cycle with flag_wr=1 and flag_wdata=0 clears brk_flag and irq on the next cycle. A cycle with flag_wr=1 and flag_wdata=1 leaves brk_flag unchanged.
- R5: After a break, once the line has returned high, win rises after the next falling edge. It falls after the fifth falling edge counted from that one.
- R6: At the close of the window, count takes the number of cycles for which win was high, and done pulses for exactly that one cycle. For a 0x55 byte sent at B clocks per bit, count equals 8*B.
- R7: count holds its value until the next break, which resets it to 0. Falling edges that arrive without a new break open no window and leave count unchanged.
- R8: If the window stays open long enough for the counter to reach its maximum value (2^CNT_W - 1), ovf is set, win drops, and done does not pulse. The next break clears ovf.
- R9: After reset, brk_flag, irq, win, done, count and ovf are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial receive line, may be asynchronous to clk |
| brk_ie | input | 1 | Break interrupt enable |
| flag_wr | input | 1 | Write strobe for the break flag |
| flag_wdata | input | 1 | Value written; 0 clears the flag, 1 has no effect |
| brk_flag | output | 1 | Break-detected status flag |
| irq | output | 1 | Interrupt request (flag AND enable) |
| win | output | 1 | Measurement window, high across eight bit times |
| done | output | 1 | One-cycle pulse when a new count is published |
| count | output | CNT_W | Clocks counted over the window |
| ovf | output | 1 | Measurement counter overflowed, result discarded |

## Verification
The assertions assume that flag_wr is sampled on the clock like any register write. They also assume that the interrupt relationships hold regardless of what rxd does, since rxd is resynchronised first. The assertion on clearing the flag excludes the cycle in which a new break is recognised, because the set takes priority there.

The stimulus changes rxd only on falling clock edges. It leaves at least one bit time of idle high between a break and the synch byte, so the wait-for-high phase is always exercised. No break is ever sent inside a measurement window. Every low run within a frame lasts at most one bit time, far below the break threshold.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  typedef enum logic [1:0] {
    GS_IDLE   = 2'd0,
    GS_WAITHI = 2'd1,
    GS_ARM    = 2'd2,
    GS_GATE   = 2'd3
  } gate_st_t;

  localparam int unsigned EDGES_PER_WINDOW = 5;
endpackage

// File: rtl/lin_rx_sync.sv
module lin_rx_sync (
  input  logic clk,
  input  logic rst,
  input  logic rxd,
  output logic line_s,
  output logic fall
);
  logic meta_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      line_s <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rxd;
      line_s <= meta_q;
      prev_q <= line_s;
    end
  end

  assign fall = prev_q & ~line_s;
endmodule

// File: rtl/lin_brk_det.sv
module lin_brk_det #(
  parameter int unsigned NOM_BIT_CLKS = 16,
  parameter int unsigned BREAK_BITS   = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic line_s,
  output logic brk_hit
);
  localparam int unsigned THR   = NOM_BIT_CLKS * BREAK_BITS;
  localparam int unsigned LOW_W = $clog2(THR + 1);

  logic [LOW_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (line_s) begin
      low_cnt <= '0;
    end else if (low_cnt != LOW_W'(THR)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign brk_hit = ~line_s & (low_cnt == LOW_W'(THR - 1));
endmodule

// File: rtl/lin_gate_meter.sv
module lin_gate_meter
  import lin_sync_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             brk_hit,
  input  logic             line_s,
  input  logic             fall,
  output logic             win,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [2:0] LAST_EDGE = 3'(EDGES_PER_WINDOW - 1);

  gate_st_t         st;
  logic [2:0]       n_fall;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= GS_IDLE;
      n_fall  <= '0;
      run_cnt <= '0;
      win     <= 1'b0;
      done    <= 1'b0;
      count   <= '0;
      ovf     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (brk_hit) begin
        st    <= GS_WAITHI;
        win   <= 1'b0;
        count <= '0;
        ovf   <= 1'b0;
      end else begin
        unique case (st)
          GS_IDLE: ;
          GS_WAITHI: if (line_s) st <= GS_ARM;
          GS_ARM: begin
            if (fall) begin
              st      <= GS_GATE;
              win     <= 1'b1;
              run_cnt <= '0;
              n_fall  <= 3'd1;
            end
          end
          GS_GATE: begin
            if (run_cnt == CNT_MAX) begin
              st  <= GS_IDLE;
              win <= 1'b0;
              ovf <= 1'b1;
            end else if (fall && n_fall == LAST_EDGE) begin
              st    <= GS_IDLE;
              win   <= 1'b0;
              done  <= 1'b1;
              count <= run_cnt + 1'b1;
            end else begin
              run_cnt <= run_cnt + 1'b1;
              if (fall) n_fall <= n_fall + 1'b1;
            end
          end
          default: st <= GS_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_sync_meter.sv
module lin_sync_meter #(
  parameter int unsigned NOM_BIT_CLKS = 16,
  parameter int unsigned BREAK_BITS   = 11,
  parameter int unsigned CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic             brk_ie,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             brk_flag,
  output logic             irq,
  output logic             win,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  logic line_s;
  logic fall;
  logic brk_hit;
  logic flag_nxt;

  lin_rx_sync u_sync (
    .clk    (clk),
    .rst    (rst),
    .rxd    (rxd),
    .line_s (line_s),
    .fall   (fall)
  );

  lin_brk_det #(
    .NOM_BIT_CLKS (NOM_BIT_CLKS),
    .BREAK_BITS   (BREAK_BITS)
  ) u_det (
    .clk     (clk),
    .rst     (rst),
    .line_s  (line_s),
    .brk_hit (brk_hit)
  );

  lin_gate_meter #(
    .CNT_W (CNT_W)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .brk_hit (brk_hit),
    .line_s  (line_s),
    .fall    (fall),
    .win     (win),
    .done    (done),
    .count   (count),
    .ovf     (ovf)
  );

  always_comb begin
    flag_nxt = brk_flag;
    if (flag_wr && !flag_wdata) flag_nxt = 1'b0;
    if (brk_hit)                flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_flag <= 1'b0;
      irq      <= 1'b0;
    end else begin
      brk_flag <= flag_nxt;
      irq      <= flag_nxt & brk_ie;
    end
  end
endmodule

// File: rtl/lin_sync_meter_chk.sv
module lin_sync_meter_chk (
  input logic clk,
  input logic rst,
  input logic brk_ie,
  input logic flag_wr,
  input logic flag_wdata,
  input logic brk_hit,
  input logic brk_flag,
  input logic irq,
  input logic win,
  input logic done,
  input logic ovf
);
  // R1
  brk_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    brk_hit |=> brk_flag);

  // R2
  irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> brk_flag);

  // R3
  ie_off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !brk_ie |=> !irq);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_wr && !flag_wdata && !brk_hit) |=> (!brk_flag && !irq));

  // R6
  done_closes_win_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!win && $fell(win)));

  // R8
  ovf_no_done_chk: assert property (@(posedge clk) disable iff (rst)
    ovf |-> !done);
endmodule

bind lin_sync_meter lin_sync_meter_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .brk_ie     (brk_ie),
  .flag_wr    (flag_wr),
  .flag_wdata (flag_wdata),
  .brk_hit    (brk_hit),
  .brk_flag   (brk_flag),
  .irq        (irq),
  .win        (win),
  .done       (done),
  .ovf        (ovf)
);

// File: tb/tb_lin_sync_meter.sv
`timescale 1ns/1ps
module tb_lin_sync_meter;
  localparam int CNT_W = 16;
  localparam int THR   = 176;
  localparam int NV    = 4;
  // bit clocks, expected count
  localparam int VEC [NV][2] = '{'{10, 80}, '{16, 128}, '{23, 184}, '{37, 296}};

  logic clk = 1'b0;
  logic rst, rxd, brk_ie, flag_wr, flag_wdata;
  logic brk_flag, irq, win, done, ovf;
  logic [CNT_W-1:0] count;

  int compared   = 0;
  int mismatched = 0;
  int done_seen  = 0;
  bit finished   = 0;

  always #2.5 clk = ~clk;

  lin_sync_meter dut (
    .clk(clk), .rst(rst), .rxd(rxd), .brk_ie(brk_ie),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .brk_flag(brk_flag), .irq(irq), .win(win), .done(done),
    .count(count), .ovf(ovf)
  );

  always @(posedge clk) if (!rst && done) done_seen++;

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_break(input int n);
    rxd = 1'b0;
    idle(n);
    rxd = 1'b1;
  endtask

  task automatic send_sync(input int b, input bit chk_win);
    logic [9:0] fr;
    fr = {1'b1, 8'h55, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rxd = fr[k];
      idle(b / 2);
      if (chk_win && k == 1) chk("R5 win open mid-frame", int'(win), 1);
      idle(b - b / 2);
    end
  endtask

  task automatic write_flag(input bit v);
    flag_wr = 1'b1; flag_wdata = v;
    @(negedge clk);
    flag_wr = 1'b0; flag_wdata = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int first;
    int d0;
    rst = 1'b1; rxd = 1'b1; brk_ie = 1'b1; flag_wr = 1'b0; flag_wdata = 1'b0;
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9 brk_flag", int'(brk_flag), 0);
    chk("R9 irq",      int'(irq), 0);
    chk("R9 win",      int'(win), 0);
    chk("R9 done",     int'(done), 0);
    chk("R9 count",    int'(count), 0);
    chk("R9 ovf",      int'(ovf), 0);

    // R1 short low run: no break
    send_break(THR - 6);
    idle(10);
    chk("R1 short low ignored", int'(brk_flag), 0);

    // Table walk: break, delimiter, synch byte, measure
    for (int i = 0; i < NV; i++) begin
      rxd = 1'b0;
      first = -1;
      for (int c = 1; c <= 200; c++) begin
        @(negedge clk);
        if (first < 0 && brk_flag) begin
          first = c;
          // R2 irq with flag in same cycle
          chk("R2 irq with flag", int'(irq), 1);
        end
      end
      rxd = 1'b1;
      chk("R1 break latency window", int'(first >= THR && first <= THR + 4), 1);
      chk("R7 count cleared by break", int'(count), 0);
      idle(VEC[i][0]);
      chk("R5 win low before synch", int'(win), 0);
      d0 = done_seen;
      send_sync(VEC[i][0], 1'b1);
      idle(8);
      chk("R5 win closed", int'(win), 0);
      chk("R6 single done", done_seen - d0, 1);
      chk("R6 count 8 bit times", int'(count), VEC[i][1]);
      write_flag(1'b1);
      chk("R4 write 1 keeps flag", int'(brk_flag), 1);
      write_flag(1'b0);
      chk("R4 write 0 clears flag", int'(brk_flag), 0);
      chk("R4 write 0 clears irq", int'(irq), 0);
    end

    // R7 synch without break: no window, count held
    d0 = done_seen;
    send_sync(20, 1'b0);
    idle(8);
    chk("R7 no done without break", done_seen - d0, 0);
    chk("R7 count held", int'(count), VEC[NV-1][1]);

    // R3 interrupt disabled
    brk_ie = 1'b0;
    send_break(200);
    idle(4);
    chk("R3 flag set with ie off", int'(brk_flag), 1);
    chk("R3 irq stays low", int'(irq), 0);
    brk_ie = 1'b1;
    idle(2);
    chk("R2 irq follows enable", int'(irq), 1);
    write_flag(1'b0);

    // R8 overflow: one falling edge then line stays high
    idle(20);
    d0 = done_seen;
    rxd = 1'b0; idle(10); rxd = 1'b1;
    idle(66000);
    chk("R8 ovf set", int'(ovf), 1);
    chk("R8 win dropped", int'(win), 0);
    chk("R8 no done", done_seen - d0, 0);
    send_break(200);
    idle(4);
    chk("R8 ovf cleared by break", int'(ovf), 0);

    finish_run();
  end
endmodule